// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a fast 12-bit port A and a slower 24-bit port B. Port B has two 12-bit halves: the low half (bits 11:0) and the high half (bits 23:12). In the A-to-B direction, two narrow words arrive on consecutive clock cycles and leave together as one wide word. The low-half path has two register stages and the high-half path has one. Because of this, the older word stays lined up with the newer one.

In the B-to-A direction, each half of B has its own capture register. A select input chooses which captured half drives A. All storage registers load on the rising clock edge, and only while their active-low enable is low. The active-low output enables and the select input are registered, so a direction change takes effect on the edge after it is requested.

Each port is modelled as separate data-in, data-out and drive-enable signals. An active-low asynchronous reset clears all data registers and leaves both output drives off.

Top module: `bus_xchg`

## Requirements
- R1: While reset is asserted and after it is released, before any control is sampled, a_oe_o and b_oe_o are 0, and a_o and b_o are all zeros.
- R2: The low half of B comes from a two-stage pipeline. On a rising edge with en_a1_ni low, stage one loads a_i and stage two loads the old value of stage one. b_o[11:0] shows stage two.
- R3: On a rising edge with en_a2_ni low, the high-half register loads a_i. b_o[23:12] shows this register.
- R4: Pairing sequence: word0 is presented with only en_a1_ni low, then word1 on the next cycle with both A enables low. After that second edge, b_o equals {word1, word0}.
- R5: Any register whose enable is high at an edge keeps its value.
- R6: On a rising edge, b_i[11:0] is captured when en_b1_ni is low, and b_i[23:12] is captured when en_b2_ni is low.
- R7: a_o shows the captured low half when the registered select is 0, and the captured high half when it is 1.
- R8: a_oe_o and b_oe_o are the inverse of oe_a_ni and oe_b_ni as sampled at the previous rising edge. A change on these inputs does not reach the outputs before that edge.
- R9: sel_i is registered. A change of sel_i does not alter a_o until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 12 | Narrow port data in |
| en_a1_ni | input | 1 | Active-low enable, both low-half pipeline stages |
| en_a2_ni | input | 1 | Active-low enable, high-half register |
| b_i | input | 24 | Wide port data in |
| en_b1_ni | input | 1 | Active-low enable, B low-half capture |
| en_b2_ni | input | 1 | Active-low enable, B high-half capture |
| sel_i | input | 1 | Half select for A output (0 low, 1 high) |
| oe_a_ni | input | 1 | Active-low drive request for port A |
| oe_b_ni | input | 1 | Active-low drive request for port B |
| a_o | output | 12 | Narrow port data out |
| a_oe_o | output | 1 | Port A drive enable, active high |
| b_o | output | 24 | Wide port data out |
| b_oe_o | output | 1 | Port B drive enable, active high |

## Verification
The hardest case to reach is the difference in depth between the two B halves. It only shows when en_a1_ni is asserted on its own after a completed pair: stage two then takes the word that was left in stage one, while the high half holds. The bench drives a full pairing, then a lone stage-one load, then a lone high-half load, and compares b_o after each step. A scoreboard queue holds every expected word pair. Select and output-enable changes are applied mid-cycle and sampled both before and after the next edge, which exposes any path that bypasses the control registers.

// File: rtl/xchg_pkg.sv
`timescale 1ns/1ps
package xchg_pkg;
  typedef struct packed {
    logic oe_a_n;
    logic oe_b_n;
    logic sel;
  } xchg_ctrl_t;

  localparam xchg_ctrl_t CTRL_RST = '{oe_a_n: 1'b1, oe_b_n: 1'b1, sel: 1'b0};
endpackage

// File: rtl/xchg_reg.sv
`timescale 1ns/1ps
module xchg_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!en_ni) q_o <= d_i;
  end
endmodule

// File: rtl/xchg_a2b.sv
`timescale 1ns/1ps
module xchg_a2b #(
  parameter int unsigned W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   a_i,
  input  logic           en_lo_ni,
  input  logic           en_hi_ni,
  output logic [2*W-1:0] wide_o
);
  logic [W-1:0] lo_s1, lo_s2, hi_q;

  // low half: two stages, both on the same enable
  xchg_reg #(.W(W)) u_lo_s1 (.clk_i, .rst_ni, .en_ni(en_lo_ni), .d_i(a_i),   .q_o(lo_s1));
  xchg_reg #(.W(W)) u_lo_s2 (.clk_i, .rst_ni, .en_ni(en_lo_ni), .d_i(lo_s1), .q_o(lo_s2));
  // high half: single stage
  xchg_reg #(.W(W)) u_hi    (.clk_i, .rst_ni, .en_ni(en_hi_ni), .d_i(a_i),   .q_o(hi_q));

  assign wide_o = {hi_q, lo_s2};
endmodule

// File: rtl/xchg_b2a.sv
`timescale 1ns/1ps
module xchg_b2a #(
  parameter int unsigned W  = 12,
  parameter int unsigned NH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NH*W-1:0] b_i,
  input  logic [NH-1:0]   en_ni,
  input  logic            sel_q_i,
  output logic [W-1:0]    a_o
);
  logic [W-1:0] half_q [NH];

  for (genvar h = 0; h < NH; h++) begin : g_half
    xchg_reg #(.W(W)) u_cap (
      .clk_i, .rst_ni,
      .en_ni(en_ni[h]),
      .d_i  (b_i[h*W +: W]),
      .q_o  (half_q[h])
    );
  end

  assign a_o = sel_q_i ? half_q[1] : half_q[0];
endmodule

// File: rtl/bus_xchg.sv
`timescale 1ns/1ps
module bus_xchg #(
  parameter int unsigned W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   a_i,
  input  logic           en_a1_ni,
  input  logic           en_a2_ni,
  input  logic [2*W-1:0] b_i,
  input  logic           en_b1_ni,
  input  logic           en_b2_ni,
  input  logic           sel_i,
  input  logic           oe_a_ni,
  input  logic           oe_b_ni,
  output logic [W-1:0]   a_o,
  output logic           a_oe_o,
  output logic [2*W-1:0] b_o,
  output logic           b_oe_o
);
  import xchg_pkg::*;

  xchg_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= '{oe_a_n: oe_a_ni, oe_b_n: oe_b_ni, sel: sel_i};
  end

  xchg_a2b #(.W(W)) u_a2b (
    .clk_i, .rst_ni, .a_i,
    .en_lo_ni(en_a1_ni),
    .en_hi_ni(en_a2_ni),
    .wide_o  (b_o)
  );

  xchg_b2a #(.W(W), .NH(2)) u_b2a (
    .clk_i, .rst_ni, .b_i,
    .en_ni  ({en_b2_ni, en_b1_ni}),
    .sel_q_i(ctrl_q.sel),
    .a_o
  );

  assign a_oe_o = ~ctrl_q.oe_a_n;
  assign b_oe_o = ~ctrl_q.oe_b_n;
endmodule

// File: rtl/bus_xchg_chk.sv
`timescale 1ns/1ps
module bus_xchg_chk #(
  parameter int unsigned W = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [W-1:0]   a_i,
  input logic           en_a1_ni,
  input logic           en_a2_ni,
  input logic [2*W-1:0] b_i,
  input logic           en_b1_ni,
  input logic           en_b2_ni,
  input logic           sel_i,
  input logic           oe_a_ni,
  input logic           oe_b_ni,
  input logic [W-1:0]   a_o,
  input logic           a_oe_o,
  input logic [2*W-1:0] b_o,
  input logic           b_oe_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r8_oe_b_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> b_oe_o == !$past(oe_b_ni));

  a_r8_oe_a_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> a_oe_o == !$past(oe_a_ni));

  a_r5_hold_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(en_a2_ni)) |-> $stable(b_o[2*W-1:W]));

  a_r3_load_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(en_a2_ni)) |-> b_o[2*W-1:W] == $past(a_i));

  a_r7_sel_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(sel_i) && !$past(en_b1_ni)) |-> a_o == $past(b_i[W-1:0]));

  a_r7_sel_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(sel_i) && !$past(en_b2_ni)) |-> a_o == $past(b_i[2*W-1:W]));
endmodule

bind bus_xchg bus_xchg_chk #(.W(W)) u_chk (.*);

// File: tb/bus_xchg_bench.sv
`timescale 1ns/1ps
module bus_xchg_bench;
  localparam int W = 12;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [W-1:0]   a_i = '0;
  logic           en_a1_ni = 1'b1, en_a2_ni = 1'b1;
  logic [2*W-1:0] b_i = '0;
  logic           en_b1_ni = 1'b1, en_b2_ni = 1'b1;
  logic           sel_i = 1'b0;
  logic           oe_a_ni = 1'b1, oe_b_ni = 1'b1;
  logic [W-1:0]   a_o;
  logic           a_oe_o, b_oe_o;
  logic [2*W-1:0] b_o;

  int checks = 0;
  int failures = 0;
  logic [2*W-1:0] exp_q[$];
  logic chk_pair = 1'b0;
  logic done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bus_xchg #(.W(W)) u_bus_xchg (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: pairing sequence; pushes expected wide word
  task automatic send_pair(input logic [W-1:0] w0, input logic [W-1:0] w1);
    exp_q.push_back({w1, w0});
    @(negedge clk_i); a_i = w0; en_a1_ni = 1'b0; en_a2_ni = 1'b1;
    @(negedge clk_i); a_i = w1; en_a1_ni = 1'b0; en_a2_ni = 1'b0;
    @(negedge clk_i); a_i = ~w1; en_a1_ni = 1'b1; en_a2_ni = 1'b1; chk_pair = 1'b1;
    @(negedge clk_i); chk_pair = 1'b0;
  endtask

  // monitor: one edge after pairing, with enables high (R4 value, R5 hold)
  always @(posedge clk_i) begin
    #1;
    if (chk_pair) begin
      logic [2*W-1:0] e;
      e = exp_q.pop_front();
      check("R4 pair", 32'(b_o), 32'(e));
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 a_oe", 32'(a_oe_o), 0);
    check("R1 b_oe", 32'(b_oe_o), 0);
    check("R1 b_o", 32'(b_o), 0);
    check("R1 a_o", 32'(a_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 b_oe after release", 32'(b_oe_o), 0);

    // R8: output enables registered
    oe_b_ni = 1'b0; #1;
    check("R8 b_oe before edge", 32'(b_oe_o), 0);
    @(negedge clk_i);
    check("R8 b_oe after edge", 32'(b_oe_o), 1);
    oe_a_ni = 1'b0; oe_b_ni = 1'b1; #1;
    check("R8 a_oe before edge", 32'(a_oe_o), 0);
    @(negedge clk_i);
    check("R8 a_oe after edge", 32'(a_oe_o), 1);
    check("R8 b_oe off", 32'(b_oe_o), 0);

    // R4: several pairings
    send_pair(12'h123, 12'hABC);
    send_pair(12'hFFF, 12'h000);
    send_pair(12'h5A5, 12'hA5A);

    // R2: lone stage-one load; stage two takes what stage one held (0xA5A)
    @(negedge clk_i); a_i = 12'h777; en_a1_ni = 1'b0;
    @(negedge clk_i); en_a1_ni = 1'b1; a_i = 12'h111;
    check("R2 lo from stage one", 32'(b_o[W-1:0]), 32'h5A5 ^ 32'h5A5 ^ 32'hA5A);
    check("R5 hi held", 32'(b_o[2*W-1:W]), 32'hA5A);
    @(negedge clk_i); en_a1_ni = 1'b0;
    @(negedge clk_i); en_a1_ni = 1'b1;
    check("R2 lo second stage", 32'(b_o[W-1:0]), 32'h777);

    // R3: lone high-half load
    a_i = 12'h3C3; en_a2_ni = 1'b0;
    @(negedge clk_i); en_a2_ni = 1'b1; a_i = 12'h999;
    check("R3 hi load", 32'(b_o[2*W-1:W]), 32'h3C3);
    check("R5 lo held", 32'(b_o[W-1:0]), 32'h777);

    // R6/R7: B-to-A capture and select
    b_i = 24'hDEF_456; en_b1_ni = 1'b0; en_b2_ni = 1'b0; sel_i = 1'b0;
    @(negedge clk_i); en_b1_ni = 1'b1; en_b2_ni = 1'b1; b_i = 24'h000_000;
    check("R7 sel0 low half", 32'(a_o), 32'h456);
    sel_i = 1'b1; #1;
    check("R9 sel before edge", 32'(a_o), 32'h456);
    @(negedge clk_i);
    check("R7 sel1 high half", 32'(a_o), 32'hDEF);
    // R6: only high half captured
    b_i = 24'h2B2_1A1; en_b2_ni = 1'b0;
    @(negedge clk_i); en_b2_ni = 1'b1;
    check("R6 hi capture", 32'(a_o), 32'h2B2);
    sel_i = 1'b0;
    @(negedge clk_i);
    check("R6 lo held", 32'(a_o), 32'h456);
    b_i = 24'h000_C0C; en_b1_ni = 1'b0;
    @(negedge clk_i); en_b1_ni = 1'b1;
    check("R6 lo capture", 32'(a_o), 32'hC0C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule